// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits on the bus of an 8-bit processor whose low address byte and data byte share one set of pins. It keeps the low address byte, captured during the address strobe, so that the decode logic always works on a stable full address after the pins switch over to carrying data. From that address, the I/O-or-memory status line and the read and write strobes, it raises one RAM select for a single 8 KiB memory window and selects two I/O-mapped ports.

The first port is an 8-bit output register. An I/O write to port 20H loads it, and its value stays on the block's output pins. The same port can also be read back. The second port is an 8-bit status input at port 10H, with the device's ready flag in bit 0. During an I/O read, a read multiplexer returns the one selected source together with a drive-enable signal. When no source is selected, the drive enable stays low so that the shared pins are left undriven.

The block runs on one clock. All strobes are sampled as synchronous inputs, and reset is synchronous and active high.

Top module: `mbd_top`

## Requirements
- R1: The low address byte is taken from `ad_in` in every clock cycle while `ale` is high, and is held once `ale` is low. `ram_addr[7:0]` keeps the captured byte even when `ad_in` later changes.
- R2: `ram_sel` is 1 only when `io_m` is 0, `addr_hi[7:5]` equals 3'b010 (addresses 4000H to 5FFFH) and `rd_n` or `wr_n` is low. At the same time `ram_addr` equals `{addr_hi[4:0], captured low byte}`.
- R3: Memory addresses outside 4000H to 5FFFH never raise `ram_sel`. This includes 6000H to 7FFFH, whose top three bits are 011.
- R4: With `io_m` = 1, `ram_sel` stays 0 whatever the address. With `io_m` = 0, neither port is selected, so a memory read at an address whose low byte is 10H or 20H leaves `rd_drive_en` at 0.
- R5: `out_port` resets to 00H. An I/O write (`io_m` = 1, `wr_n` low) to port 20H loads the byte present on `ad_in` while `wr_n` is low, and the new value appears after `wr_n` rises.
- R6: Writes to any other I/O port, and memory writes whose low address byte is 20H, leave `out_port` unchanged.
- R7: An I/O read from port 10H sets `rd_drive_en` to 1 and puts `status_in` on `rd_data`, including the ready flag in bit 0.
- R8: An I/O read from port 20H sets `rd_drive_en` to 1 and returns the current `out_port` value on `rd_data`.
- R9: In every other case (an I/O read from an unused port, any memory cycle, or `rd_n` high) `rd_drive_en` is 0 and `rd_data` is 00H.
- R10: At most one read source is selected at a time, and `rd_drive_en` is 1 only while `rd_n` is low during an I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; the low byte on `ad_in` is valid while high |
| io_m | input | 1 | Cycle type: 1 for I/O, 0 for memory |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_hi | input | 8 | Upper address byte |
| ad_in | input | 8 | Shared pins: low address byte, then data |
| status_in | input | 8 | Device status lines; bit 0 is the ready flag |
| ram_sel | output | 1 | RAM chip select, active high |
| ram_addr | output | 13 | Address passed to the RAM |
| rd_data | output | 8 | Data for the processor during an I/O read |
| rd_drive_en | output | 1 | 1 when `rd_data` should drive the shared pins |
| out_port | output | 8 | Value held by the output register |

## Verification
The assertions assume a well-formed bus cycle: `ale` is high for at least one clock before a strobe goes low, `rd_n` and `wr_n` are never low together, and `io_m`, `addr_hi` and the captured address do not change while a strobe is low. The bench builds every access with one task that follows this order. It holds the strobe low for two clocks and changes `ad_in` only after `ale` has fallen, so the address-hold and write-capture properties are only ever checked on legal cycles. The bench also puts a deliberately different value on `ad_in` during read cycles, which shows that the decoder uses the captured byte and not the live pins.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [1:0] {
        RSRC_NONE   = 2'd0,
        RSRC_STATUS = 2'd1,
        RSRC_OUTREG = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic ram;
        logic io_stat;
        logic io_out;
    } sel_t;

    function automatic rd_src_e pick_src(input sel_t s, input logic rd_n);
        rd_src_e r;
        r = RSRC_NONE;
        if (!rd_n) begin
            if (s.io_stat)     r = RSRC_STATUS;
            else if (s.io_out) r = RSRC_OUTREG;
        end
        return r;
    endfunction

endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ale,
    input  logic [W-1:0] ad_in,
    output logic [W-1:0] low_addr
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)      held_q <= '0;
        else if (ale) held_q <= ad_in;
    end

    // transparent while the strobe is high, holding once it drops
    assign low_addr = ale ? ad_in : held_q;

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(ale) && !$past(rst)) |-> $stable(held_q));

endmodule

// File: rtl/mbd_decode.sv
module mbd_decode
    import mbd_pkg::*;
#(
    parameter int                   HI_W        = 8,
    parameter int                   LO_W        = 8,
    parameter int                   RAM_HI_BITS = 3,
    parameter logic [RAM_HI_BITS-1:0] RAM_HI_PAT = 3'b010,
    parameter logic [LO_W-1:0]      STAT_PORT   = 8'h10,
    parameter logic [LO_W-1:0]      OUT_PORT    = 8'h20
) (
    input  logic            io_m,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [HI_W-1:0] addr_hi,
    input  logic [LO_W-1:0] low_addr,
    output sel_t            sel
);
    logic strobe;
    logic hi_hit;

    assign strobe = !rd_n || !wr_n;
    assign hi_hit = (addr_hi[HI_W-1 -: RAM_HI_BITS] == RAM_HI_PAT);

    always_comb begin
        sel         = '0;
        sel.ram     = !io_m && strobe && hi_hit;
        sel.io_stat = io_m && strobe && (low_addr == STAT_PORT);
        sel.io_out  = io_m && strobe && (low_addr == OUT_PORT);
    end

endmodule

// File: rtl/mbd_out_port.sv
module mbd_out_port #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_n,
    input  logic         sel,
    input  logic [W-1:0] ad_in,
    output logic [W-1:0] out_q
);
    logic         wr_n_q;
    logic         sel_q;
    logic [W-1:0] wdata_q;
    logic         wr_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q  <= 1'b1;
            sel_q   <= 1'b0;
            wdata_q <= '0;
        end else begin
            wr_n_q <= wr_n;
            if (!wr_n) begin
                sel_q   <= sel;
                wdata_q <= ad_in;
            end
        end
    end

    assign wr_rise = wr_n && !wr_n_q;

    always_ff @(posedge clk) begin
        if (rst)                   out_q <= RST_VAL;
        else if (wr_rise && sel_q) out_q <= wdata_q;
    end

    assert_out_change_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(out_q) && !$past(rst)) |-> ($past(wr_n) && !$past(wr_n, 2)));

endmodule

// File: rtl/mbd_top.sv
module mbd_top
    import mbd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int RAM_HI_BITS = 3,
    parameter logic [RAM_HI_BITS-1:0] RAM_HI_PAT = 3'b010,
    parameter logic [DATA_W-1:0] STAT_PORT = 8'h10,
    parameter logic [DATA_W-1:0] OUT_PORT  = 8'h20,
    parameter logic [DATA_W-1:0] OUT_RST   = 8'h00,
    localparam int HI_W   = ADDR_W - DATA_W,
    localparam int RAM_AW = ADDR_W - RAM_HI_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              io_m,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [DATA_W-1:0] status_in,
    output logic              ram_sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive_en,
    output logic [DATA_W-1:0] out_port
);
    logic [DATA_W-1:0] low_addr;
    sel_t              sel;
    rd_src_e           src;

    mbd_addr_latch #(.W(DATA_W)) addr_latch_i (
        .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .low_addr(low_addr)
    );

    mbd_decode #(
        .HI_W(HI_W), .LO_W(DATA_W), .RAM_HI_BITS(RAM_HI_BITS),
        .RAM_HI_PAT(RAM_HI_PAT), .STAT_PORT(STAT_PORT), .OUT_PORT(OUT_PORT)
    ) decode_i (
        .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .addr_hi(addr_hi), .low_addr(low_addr), .sel(sel)
    );

    mbd_out_port #(.W(DATA_W), .RST_VAL(OUT_RST)) out_port_i (
        .clk(clk), .rst(rst), .wr_n(wr_n), .sel(sel.io_out),
        .ad_in(ad_in), .out_q(out_port)
    );

    assign ram_sel  = sel.ram;
    assign ram_addr = {addr_hi[HI_W-RAM_HI_BITS-1:0], low_addr};

    always_comb begin
        src = pick_src(sel, rd_n);
        unique case (src)
            RSRC_STATUS: rd_data = status_in;
            RSRC_OUTREG: rd_data = out_port;
            default:     rd_data = '0;
        endcase
        rd_drive_en = (src != RSRC_NONE);
    end

    assert_ram_mem_only_R4: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> !io_m);
    assert_ram_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> (!rd_n || !wr_n));
    assert_one_source_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.io_stat, sel.io_out}));
    assert_drive_qual_R10: assert property (@(posedge clk) disable iff (rst)
        rd_drive_en |-> (!rd_n && io_m && !ram_sel));
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_drive_en |-> (rd_data == '0));

endmodule

// File: tb/mbd_top_tb_top.sv
module mbd_top_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       ale, io_m, rd_n, wr_n;
    logic [7:0] addr_hi, ad_in, status_in;
    logic       ram_sel, rd_drive_en;
    logic [12:0] ram_addr;
    logic [7:0] rd_data, out_port;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mbd_top dut_i (
        .clk(clk), .rst(rst), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .addr_hi(addr_hi), .ad_in(ad_in), .status_in(status_in),
        .ram_sel(ram_sel), .ram_addr(ram_addr), .rd_data(rd_data),
        .rd_drive_en(rd_drive_en), .out_port(out_port)
    );

    // {io, write, addr[15:0], data, status, exp_ram, exp_drv, exp_rdata, exp_out}
    localparam int NV = 17;
    localparam logic [51:0] VEC [NV] = '{
        {1'b0,1'b0,16'h4000,8'h00,8'h00,1'b1,1'b0,8'h00,8'h00}, // R2 base
        {1'b0,1'b0,16'h5FFF,8'h00,8'h00,1'b1,1'b0,8'h00,8'h00}, // R2 top
        {1'b0,1'b1,16'h4ABC,8'h77,8'h00,1'b1,1'b0,8'h00,8'h00}, // R2 write
        {1'b0,1'b0,16'h6000,8'h00,8'h00,1'b0,1'b0,8'h00,8'h00}, // R3
        {1'b0,1'b0,16'h7FFF,8'h00,8'h00,1'b0,1'b0,8'h00,8'h00}, // R3
        {1'b0,1'b0,16'h3FFF,8'h00,8'h00,1'b0,1'b0,8'h00,8'h00}, // R3
        {1'b0,1'b1,16'h0020,8'h99,8'h00,1'b0,1'b0,8'h00,8'h00}, // R6 memory at port byte
        {1'b1,1'b1,16'h2020,8'hA5,8'h00,1'b0,1'b0,8'h00,8'hA5}, // R5
        {1'b1,1'b0,16'h2020,8'h00,8'h00,1'b0,1'b1,8'hA5,8'hA5}, // R8
        {1'b1,1'b0,16'h1010,8'h00,8'h01,1'b0,1'b1,8'h01,8'hA5}, // R7 ready
        {1'b1,1'b0,16'h1010,8'h00,8'hFE,1'b0,1'b1,8'hFE,8'hA5}, // R7 not ready
        {1'b1,1'b1,16'h3030,8'h11,8'h00,1'b0,1'b0,8'h00,8'hA5}, // R6 other port
        {1'b1,1'b1,16'h1010,8'h22,8'h00,1'b0,1'b0,8'h00,8'hA5}, // R6 status port
        {1'b1,1'b0,16'h4040,8'h00,8'hFF,1'b0,1'b0,8'h00,8'hA5}, // R4 R9
        {1'b0,1'b0,16'h4010,8'h00,8'hFF,1'b1,1'b0,8'h00,8'hA5}, // R4 memory at status byte
        {1'b1,1'b1,16'h2020,8'h3C,8'h00,1'b0,1'b0,8'h00,8'h3C}, // R5 overwrite
        {1'b1,1'b0,16'h2020,8'h00,8'h00,1'b0,1'b1,8'h3C,8'h3C}  // R8
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ale = 1'b0; io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        addr_hi = 8'h00; ad_in = 8'h00; status_in = 8'h00;
    endtask

    task automatic bus_cycle(input logic [51:0] v);
        logic io, w, er, ed;
        logic [15:0] a;
        logic [7:0] d, st, erd, eo;
        {io, w, a, d, st, er, ed, erd, eo} = v;
        @(posedge clk); #1;
        ale = 1'b1; io_m = io; addr_hi = a[15:8]; ad_in = a[7:0];
        rd_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); #1;
        ale = 1'b0; ad_in = w ? d : 8'hEE; status_in = st;
        rd_n = w; wr_n = !w;
        @(negedge clk);
        check(ram_sel == er, "R2/R3/R4 ram_sel", ram_sel, er);
        if (er) check(ram_addr == a[12:0], "R2 ram_addr", ram_addr, a[12:0]);
        check(rd_drive_en == ed, "R7/R8/R9 drive", rd_drive_en, ed);
        check(rd_data == erd, "R7/R8/R9 rd_data", rd_data, erd);
        @(posedge clk); #1;
        @(posedge clk); #1;
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        check(rd_drive_en == 1'b0, "R10 drive after rd", rd_drive_en, 0);
        @(posedge clk); #1;
        ad_in = 8'h00;
        @(negedge clk);
        check(out_port == eo, "R5/R6 out_port", out_port, eo);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // reset state
        check(out_port == 8'h00, "R5 reset out", out_port, 0);
        check(rd_drive_en == 1'b0, "R9 reset drive", rd_drive_en, 0);
        check(rd_data == 8'h00, "R9 reset rd_data", rd_data, 0);

        for (int i = 0; i < NV; i++) bus_cycle(VEC[i]);

        // R1: captured byte held after ale falls though ad_in changes
        @(posedge clk); #1;
        ale = 1'b1; io_m = 1'b0; addr_hi = 8'h41; ad_in = 8'h55;
        @(posedge clk); #1;
        ale = 1'b0; ad_in = 8'hAA;
        @(negedge clk);
        check(ram_sel == 1'b0, "R2 no strobe no select", ram_sel, 0);
        check(ram_addr == 13'h0155, "R1 held low byte", ram_addr, 13'h0155);
        @(posedge clk); #1;
        rd_n = 1'b0; ad_in = 8'h0F;
        @(negedge clk);
        check(ram_sel == 1'b1, "R2 select on read", ram_sel, 1);
        check(ram_addr == 13'h0155, "R1 hold during read", ram_addr, 13'h0155);
        check(rd_drive_en == 1'b0, "R4 mem read no drive", rd_drive_en, 0);
        @(posedge clk); #1;
        idle();

        // R1: transparent while ale high
        @(posedge clk); #1;
        ale = 1'b1; addr_hi = 8'h40; ad_in = 8'h12;
        @(negedge clk);
        check(ram_addr == 13'h0012, "R1 transparent", ram_addr, 13'h0012);
        @(posedge clk); #1;
        idle();

        // R10: I/O read selected but rd_n high -> no drive
        @(posedge clk); #1;
        ale = 1'b1; io_m = 1'b1; ad_in = 8'h10; status_in = 8'h5A;
        @(posedge clk); #1;
        ale = 1'b0;
        @(negedge clk);
        check(rd_drive_en == 1'b0, "R10 no rd no drive", rd_drive_en, 0);
        @(posedge clk); #1;
        idle();

        // R5: reset returns output register to 00H
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(out_port == 8'h00, "R5 reset clears", out_port, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule